// File: doc/BRIEF.md
# Delta Quiescent-Current Test Evaluator

This block makes the digital pass/fail decision for supply-current screening that is driven one test vector at a time. After the tester applies a vector, the block waits a programmable number of clock cycles so that switching transients can die out. It then accepts one current sample from an external converter over a valid/ready stream. The block subtracts the sample of the previous vector from the new one. It flags the vector when the magnitude of that difference is strictly greater than a programmable threshold. Each vector produces one result beat, which carries the signed delta, a fail flag and a first-vector marker.

A `start` pulse latches the settle length, the threshold and the number of vectors, and it clears all status. The first vector measured after `start` has no predecessor. It becomes the reference and is never flagged. A sticky fail flag collects every failure until the next `start`. A done flag rises once the programmed number of results has been delivered. A vector pulse that arrives while a measurement is still in progress does not restart anything: it only sets a sticky overrun flag.

Stream rules. On the sample stream, a beat transfers on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` is high only once settling has finished, and `s_valid` has no effect at any other time. On the result stream, `r_valid` stays high and `r_delta`, `r_fail` and `r_first` stay stable until a rising edge where `r_ready` is high. No new measurement starts until the result is taken. A result stalled by a low `r_ready` therefore holds off the next sample.

Top module: `qcur_delta_eval`

## Requirements
- R1: After reset, `s_ready`, `r_valid`, `fail_sticky`, `overrun` and `done` are all 0, and `vec_applied` pulses are ignored until the first `start`.
- R2: `s_ready` rises exactly `settle_cycles`+1 clock cycles after the rising edge that samples a `vec_applied` pulse. The wait uses the `settle_cycles` value latched at `start`, and 0 is a legal value.
- R3: A sample transfers on an edge where `s_valid` and `s_ready` are both 1, and `s_ready` is 0 in the following cycle. `s_valid` while `s_ready` is 0 changes nothing.
- R4: `r_delta` is the accepted sample minus the previously accepted sample, as a (SAMPLE_W+1)-bit two's-complement value. For the first vector it is the sample minus the stale previous value and carries no meaning.
- R5: `r_fail` is 1 exactly when the absolute value of `r_delta` is strictly greater than the threshold latched at `start`. A magnitude equal to the threshold passes.
- R6: For the first vector after `start`, `r_first` is 1 and `r_fail` is 0. For every later vector `r_first` is 0.
- R7: `fail_sticky` goes to 1 together with any result that has `r_fail`=1. It stays at 1 until the next `start`.
- R8: A `vec_applied` pulse that arrives during settling, while waiting for a sample, or while a result is pending sets `overrun`, which stays set until `start`. The pulse otherwise has no effect.
- R9: `done` rises on the cycle after the result numbered `vector_total` is accepted, and it holds until `start`. Once done, further vectors are ignored. With `vector_total`=0, `done` is 1 on the cycle after `start`.
- R10: `r_valid` rises in the cycle after a sample transfers. It holds with stable fields while `r_ready` is 0 and falls after the edge at which `r_ready` is 1.
- R11: `start` aborts any measurement in progress. It clears `fail_sticky`, `overrun`, `done` and the reference, and it wins over a `vec_applied` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run: latch the configuration and clear all status |
| settle_cycles | input | CNT_W | Settle wait length, latched at start |
| threshold | input | SAMPLE_W+1 | Unsigned limit on the delta magnitude, latched at start |
| vector_total | input | VEC_W | Number of vectors in the run, latched at start |
| vec_applied | input | 1 | One-cycle pulse: a new test vector has been applied |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (settling has finished) |
| s_data | input | SAMPLE_W | Unsigned current sample |
| r_valid | output | 1 | Result stream valid |
| r_ready | input | 1 | Result stream ready |
| r_delta | output | SAMPLE_W+1 | Signed delta signature |
| r_fail | output | 1 | Delta magnitude is over the threshold |
| r_first | output | 1 | Result belongs to the reference vector |
| fail_sticky | output | 1 | At least one failure since start |
| overrun | output | 1 | A vector pulse arrived while a measurement was busy |
| done | output | 1 | All programmed vectors have been evaluated |

## Verification
The bench builds the block with an 8-bit settle counter, a 4-bit vector count and full 16-bit samples. Settle lengths of 0 and a few cycles can therefore be timed cycle by cycle, and runs can be finished and restarted many times in a short simulation. Full-width samples let the deltas reach both extremes, +65535 and -65535. A threshold of 0 and deltas equal to the threshold exercise the strict comparison. Stalls on both streams, stray sample beats during settling, vector pulses in every busy phase, an abort mid-run and an empty run are all compared against a behavioural model on every clock.

// File: rtl/qde_pkg.sv
package qde_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE,
    ST_SAMPLE,
    ST_REPORT,
    ST_DONE
  } qde_state_e;
endpackage

// File: rtl/qde_settle_timer.sv
module qde_settle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (run && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && !expired |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/qde_delta_unit.sv
module qde_delta_unit #(
  parameter int SAMPLE_W = 16
) (
  input  logic                  [SAMPLE_W-1:0] cur,
  input  logic                  [SAMPLE_W-1:0] prev,
  input  logic                  [SAMPLE_W:0]   thr,
  input  logic                                 has_ref,
  output logic signed           [SAMPLE_W:0]   delta,
  output logic                                 over
);
  localparam int D_W = SAMPLE_W + 1;

  logic [D_W-1:0] mag;

  always_comb begin
    delta = $signed({1'b0, cur}) - $signed({1'b0, prev});
    mag   = delta[D_W-1] ? $unsigned(-delta) : $unsigned(delta);
    over  = has_ref && (mag > thr);
  end
endmodule

// File: rtl/qde_seq.sv
module qde_seq
  import qde_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] total_in,
  input  logic             vec_applied,
  input  logic             s_valid,
  input  logic             r_ready,
  input  logic             timer_expired,
  input  logic             delta_fail,
  output logic             timer_load,
  output logic             timer_run,
  output logic             capture,
  output logic             have_ref,
  output logic             s_ready,
  output logic             r_valid,
  output logic             r_fail,
  output logic             r_first,
  output logic             fail_sticky,
  output logic             overrun,
  output logic             done
);
  qde_state_e       state_q, state_d;
  logic [VEC_W-1:0] vec_cnt;
  logic [VEC_W-1:0] total_q;
  logic             busy;
  logic             last_vec;

  assign busy       = (state_q == ST_SETTLE) || (state_q == ST_SAMPLE) || (state_q == ST_REPORT);
  assign s_ready    = (state_q == ST_SAMPLE);
  assign r_valid    = (state_q == ST_REPORT);
  assign capture    = s_ready && s_valid;
  assign timer_load = (state_q == ST_WAIT) && vec_applied;
  assign timer_run  = (state_q == ST_SETTLE);
  assign last_vec   = (vec_cnt == total_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = ST_IDLE;
      ST_WAIT:   if (vec_applied) state_d = ST_SETTLE;
      ST_SETTLE: if (timer_expired) state_d = ST_SAMPLE;
      ST_SAMPLE: if (s_valid) state_d = ST_REPORT;
      ST_REPORT: if (r_ready) state_d = last_vec ? ST_DONE : ST_WAIT;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      vec_cnt     <= '0;
      total_q     <= '0;
      have_ref    <= 1'b0;
      r_fail      <= 1'b0;
      r_first     <= 1'b0;
      fail_sticky <= 1'b0;
      overrun     <= 1'b0;
      done        <= 1'b0;
    end else if (start) begin
      state_q     <= (total_in == '0) ? ST_DONE : ST_WAIT;
      vec_cnt     <= '0;
      total_q     <= total_in;
      have_ref    <= 1'b0;
      r_fail      <= 1'b0;
      r_first     <= 1'b0;
      fail_sticky <= 1'b0;
      overrun     <= 1'b0;
      done        <= (total_in == '0);
    end else begin
      state_q <= state_d;
      if (vec_applied && busy) overrun <= 1'b1;
      if (capture) begin
        r_first  <= !have_ref;
        r_fail   <= delta_fail;
        have_ref <= 1'b1;
        vec_cnt  <= vec_cnt + 1'b1;
        if (delta_fail) fail_sticky <= 1'b1;
      end
      if (r_valid && r_ready && last_vec) done <= 1'b1;
    end
  end

  // R6
  first_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_first |-> !r_fail);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sticky && !start |=> fail_sticky);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_applied && !start && (state_q == ST_SETTLE) |=> overrun);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !s_ready);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready && !start |=> r_valid && $stable(r_fail) && $stable(r_first));
endmodule

// File: rtl/qcur_delta_eval.sv
module qcur_delta_eval #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 24,
  parameter int VEC_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CNT_W-1:0]           settle_cycles,
  input  logic [SAMPLE_W:0]          threshold,
  input  logic [VEC_W-1:0]           vector_total,
  input  logic                       vec_applied,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [SAMPLE_W-1:0]        s_data,
  output logic                       r_valid,
  input  logic                       r_ready,
  output logic signed [SAMPLE_W:0]   r_delta,
  output logic                       r_fail,
  output logic                       r_first,
  output logic                       fail_sticky,
  output logic                       overrun,
  output logic                       done
);
  localparam int D_W = SAMPLE_W + 1;

  logic [CNT_W-1:0]        settle_q;
  logic [D_W-1:0]          thr_q;
  logic [SAMPLE_W-1:0]     prev_q;
  logic signed [D_W-1:0]   delta_w;
  logic                    over_w;
  logic                    timer_load, timer_run, timer_expired;
  logic                    capture, have_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      thr_q    <= '0;
      prev_q   <= '0;
      r_delta  <= '0;
    end else begin
      if (start) begin
        settle_q <= settle_cycles;
        thr_q    <= threshold;
      end else if (capture) begin
        prev_q  <= s_data;
        r_delta <= delta_w;
      end
    end
  end

  qde_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load && !start),
    .load_val (settle_q),
    .run      (timer_run),
    .expired  (timer_expired)
  );

  qde_delta_unit #(.SAMPLE_W(SAMPLE_W)) u_delta (
    .cur     (s_data),
    .prev    (prev_q),
    .thr     (thr_q),
    .has_ref (have_ref),
    .delta   (delta_w),
    .over    (over_w)
  );

  qde_seq #(.VEC_W(VEC_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .total_in      (vector_total),
    .vec_applied   (vec_applied),
    .s_valid       (s_valid),
    .r_ready       (r_ready),
    .timer_expired (timer_expired),
    .delta_fail    (over_w),
    .timer_load    (timer_load),
    .timer_run     (timer_run),
    .capture       (capture),
    .have_ref      (have_ref),
    .s_ready       (s_ready),
    .r_valid       (r_valid),
    .r_fail        (r_fail),
    .r_first       (r_first),
    .fail_sticky   (fail_sticky),
    .overrun       (overrun),
    .done          (done)
  );

  // R3
  sample_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !start |=> r_valid && !s_ready);
  // R4
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready && !start |=> $stable(r_delta));
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !fail_sticky && !overrun && !r_valid && !s_ready);
endmodule

// File: tb/qcur_delta_eval_tb.sv
`timescale 1ns/1ps
module qcur_delta_eval_tb;
  localparam int SW = 16;
  localparam int CW = 8;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] settle_cycles = '0;
  logic [SW:0] threshold = '0;
  logic [VW-1:0] vector_total = '0;
  logic vec_applied = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SW-1:0] s_data = '0;
  logic r_valid;
  logic r_ready = 1'b0;
  logic signed [SW:0] r_delta;
  logic r_fail, r_first, fail_sticky, overrun, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  qcur_delta_eval #(.SAMPLE_W(SW), .CNT_W(CW), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .threshold(threshold), .vector_total(vector_total), .vec_applied(vec_applied),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .r_valid(r_valid),
    .r_ready(r_ready), .r_delta(r_delta), .r_fail(r_fail), .r_first(r_first),
    .fail_sticky(fail_sticky), .overrun(overrun), .done(done));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase 0 idle,1 wait,2 settle,3 sample,4 report,5 done
  int m_phase = 0, m_left = 0, m_prev = 0, m_cnt = 0, m_total = 0;
  int m_thr = 0, m_settle = 0, m_delta = 0, m_mag = 0;
  bit m_have = 0, m_fail = 0, m_first = 0, m_sticky = 0, m_ovr = 0, m_done = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_have = 0; m_fail = 0; m_first = 0;
      m_sticky = 0; m_ovr = 0; m_done = 0; m_cnt = 0;
    end else if (start) begin
      m_settle = settle_cycles; m_thr = threshold; m_total = vector_total;
      m_have = 0; m_sticky = 0; m_ovr = 0; m_cnt = 0; m_fail = 0; m_first = 0;
      m_done = (vector_total == 0);
      m_phase = m_done ? 5 : 1;
    end else begin
      if (vec_applied && m_phase >= 2 && m_phase <= 4) m_ovr = 1;
      case (m_phase)
        1: if (vec_applied) begin m_left = m_settle; m_phase = 2; end
        2: if (m_left == 0) m_phase = 3; else m_left--;
        3: if (s_valid) begin
             m_delta = int'(s_data) - m_prev;
             m_mag = (m_delta < 0) ? -m_delta : m_delta;
             m_first = !m_have;
             m_fail = m_have && (m_mag > m_thr);
             if (m_fail) m_sticky = 1;
             m_prev = s_data; m_have = 1; m_cnt++;
             m_phase = 4;
           end
        4: if (r_ready) begin
             if (m_cnt == m_total) begin m_phase = 5; m_done = 1; end
             else m_phase = 1;
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 s_ready", s_ready, m_phase == 3);
      chk("R10 r_valid", r_valid, m_phase == 4);
      if (r_valid && m_phase == 4) begin
        chk("R6 r_first", r_first, m_first);
        chk("R5 r_fail", r_fail, m_fail);
        if (!m_first) chk("R4 r_delta", longint'(r_delta), m_delta);
      end
      chk("R7 fail_sticky", fail_sticky, m_sticky);
      chk("R8 overrun", overrun, m_ovr);
      chk("R9 done", done, m_done);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic pulse_vec();
    vec_applied = 1'b1;
    @(negedge clk);
    vec_applied = 1'b0;
  endtask

  task automatic do_start(input int st, input int thr, input int tot);
    settle_cycles = CW'(st); threshold = (SW+1)'(thr); vector_total = VW'(tot);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input int data, input int sdly, input int rdly);
    pulse_vec();
    while (!s_ready) @(negedge clk);
    repeat (sdly) @(negedge clk);
    s_valid = 1'b1; s_data = SW'(data);
    @(negedge clk);
    s_valid = 1'b0;
    chk("R3 ready drops after transfer", s_ready, 0);
    while (!r_valid) @(negedge clk);
    repeat (rdly) @(negedge clk);
    r_ready = 1'b1;
    @(negedge clk);
    r_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset s_ready", s_ready, 0);
    chk("R1 reset r_valid", r_valid, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_vec();
    repeat (4) @(negedge clk);
    chk("R1 vector before start ignored", s_ready, 0);

    do_start(3, 100, 5);
    run_vec(1000, 0, 0);
    run_vec(1050, 2, 1);
    run_vec(1200, 0, 3);
    run_vec(1100, 1, 0);
    run_vec(900, 0, 2);
    @(negedge clk);
    chk("R9 done after last result", done, 1);
    pulse_vec();
    repeat (3) @(negedge clk);
    chk("R9 vector ignored when done", s_ready, 0);

    do_start(5, 10, 3);
    chk("R11 sticky cleared", fail_sticky, 0);
    chk("R11 done cleared", done, 0);
    pulse_vec();
    s_valid = 1'b1; s_data = 16'hBEEF;
    @(negedge clk);
    s_valid = 1'b0;
    pulse_vec();
    while (!s_ready) @(negedge clk);
    pulse_vec();
    s_valid = 1'b1; s_data = 16'd500;
    @(negedge clk);
    s_valid = 1'b0;
    pulse_vec();
    r_ready = 1'b1; @(negedge clk); r_ready = 1'b0;
    run_vec(511, 0, 0);
    run_vec(500, 3, 0);

    do_start(0, 0, 4);
    run_vec(0, 0, 0);
    run_vec(65535, 0, 1);
    run_vec(65535, 1, 0);
    run_vec(0, 0, 0);
    @(negedge clk);

    do_start(4, 0, 3);
    run_vec(7, 0, 0);
    pulse_vec();
    repeat (2) @(negedge clk);
    vec_applied = 1'b1;
    do_start(2, 50, 1);
    vec_applied = 1'b0;
    chk("R11 abort clears overrun", overrun, 0);
    repeat (3) @(negedge clk);
    chk("R11 start beats same-cycle vector", s_ready, 0);
    run_vec(300, 0, 0);
    @(negedge clk);

    do_start(1, 1, 0);
    chk("R9 empty run done", done, 1);
    repeat (3) @(negedge clk);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule